// File: doc/BRIEF.md
# Eight-Sector Interpolated Edge Thinning with Dual Threshold

This block turns a frame of per-pixel gradients into a one-bit-per-pixel edge map. Each pixel arrives as a horizontal and a vertical gradient component, each given as a sign bit and an absolute value. The block forms a gradient magnitude, picks one of eight direction sectors from the two sign bits and a comparison of the two absolute values, and thins edges. A pixel survives only if its magnitude is not smaller than the magnitudes interpolated on both sides of it along the gradient direction. The surviving pixels are graded against a high and a low threshold. Strong pixels become edges, and weak pixels become edges only when a strong pixel touches them in the 3x3 window.

The block works frame by frame under a three-state controller. In `ST_LOAD` it accepts `IMG_W*IMG_H` pixels in raster order while `in_ready` is high. The transition LOAD-to-SUPPRESS fires when the last pixel is accepted, and it samples the thresholds. `ST_SUPPRESS` walks every pixel once, one per cycle, and stores its grade (none, weak or strong). The transition SUPPRESS-to-LINK fires after the last pixel is graded. `ST_LINK` walks every pixel once more and resolves weak pixels against their neighbours. The transition LINK-to-LOAD fires after the last pixel and reopens the input. The edge bits come out in raster order, one per cycle, each one a cycle after the pixel is visited.

Top module: `edge_nms8`

## Requirements
- R1: After reset `in_ready` is 1 and `out_valid` is 0. A frame is exactly `IMG_W*IMG_H` accepted pixels in raster order. After the last one, `in_ready` stays 0 until the frame's outputs are done. `out_valid` then pulses exactly `IMG_W*IMG_H` times on consecutive cycles, in raster order. `in_ready` returns to 1 in the same cycle as the last output.
- R2: The magnitude is |Gx|+|Gy|, clamped to 2^MW-1 (2047 by default).
- R3: A sign bit of 1 means negative. Rows grow downward and columns grow rightward. The forward step is dx=+1 column when the x sign is 0 (else -1) and dy=+1 row when the y sign is 0 (else -1). If |Gx|>=|Gy| the forward pair is (r, c+dx) as primary and (r+dy, c+dx) as diagonal. Otherwise the forward pair is (r+dy, c) as primary and (r+dy, c+dx) as diagonal. The backward pair uses -dx and -dy. Inverting both signs of every pixel therefore leaves the output unchanged.
- R4: With major = max(|Gx|,|Gy|) and minor = the other, a pixel of magnitude M is kept when M*major >= minor*diag + (major-minor)*primary holds for both the forward and the backward pair. Ties are kept.
- R5: A neighbour outside the frame counts as magnitude 0 and as not strong.
- R6: A kept pixel with M >= high threshold is strong and is output as 1.
- R7: A kept pixel with low <= M < high is weak. It is output as 1 if any of its eight neighbours is strong, and as 0 otherwise.
- R8: A suppressed pixel, or a kept pixel with M < low threshold, is output as 0.
- R9: Both thresholds are sampled in the cycle the last pixel of a frame is accepted. Later changes do not affect that frame.
- R10: `in_valid` with any data is ignored while `in_ready` is 0.
- R11: The caller keeps low <= high at the sampling cycle. With low == high, no pixel is weak.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_hi | input | MW | High threshold |
| thr_lo | input | MW | Low threshold |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Block accepts a pixel this cycle |
| in_sx | input | 1 | Sign of horizontal gradient (1 = negative) |
| in_ax | input | GW | Absolute horizontal gradient |
| in_sy | input | 1 | Sign of vertical gradient (1 = negative) |
| in_ay | input | GW | Absolute vertical gradient |
| out_valid | output | 1 | Edge bit present |
| out_edge | output | 1 | Edge candidate bit |

## Verification
The bench goes after four corner cases, each of which a faulty design would show in the edge map.
- Saturation: a frame of large gradients only matches if sums are clamped. Without the clamp, a brighter neighbour would wrongly suppress a pixel.
- Sector mirroring: a frame rerun with all signs inverted must give the same map. A mistake in mirroring the neighbour pair would change it.
- Thresholds and borders: equal thresholds, a zero low threshold and border pixels each expose an off-by-one compare or a wrong out-of-frame value.
- Isolated pixels and busy-time stimulus: a sparse frame holds an isolated weak pixel that must clear and a weak pixel touching a strong one that must be promoted. Garbage inputs and threshold changes during processing must leave the next frame and the current frame untouched.

// File: rtl/nms8_pkg.sv
package nms8_pkg;
    typedef enum logic [1:0] {
        ST_LOAD     = 2'd0,
        ST_SUPPRESS = 2'd1,
        ST_LINK     = 2'd2
    } state_t;

    typedef enum logic [1:0] {
        CLS_NONE   = 2'd0,
        CLS_WEAK   = 2'd1,
        CLS_STRONG = 2'd2
    } cls_t;
endpackage

// File: rtl/nms8_mag.sv
module nms8_mag #(
    parameter int GW = 11,
    parameter int MW = 11
) (
    input  logic [GW-1:0] ax,
    input  logic [GW-1:0] ay,
    output logic [MW-1:0] mag,
    output logic          x_major
);
    localparam logic [31:0] MAXM = 32'((64'd1 << MW) - 64'd1);
    logic [31:0] sum;

    always_comb begin
        sum     = 32'(ax) + 32'(ay);
        mag     = (sum > MAXM) ? MAXM[MW-1:0] : sum[MW-1:0];
        x_major = (ax >= ay);
    end
endmodule

// File: rtl/nms8_cmp.sv
module nms8_cmp #(
    parameter int GW = 11,
    parameter int MW = 11
) (
    input  logic [MW-1:0] mag,
    input  logic [GW-1:0] ax,
    input  logic [GW-1:0] ay,
    input  logic          x_major,
    input  logic [MW-1:0] fwd_prim,
    input  logic [MW-1:0] fwd_diag,
    input  logic [MW-1:0] bwd_prim,
    input  logic [MW-1:0] bwd_diag,
    output logic          keep
);
    localparam int PW = MW + GW + 1;
    logic [GW-1:0] maj, mnr, gap;
    logic [PW-1:0] lhs, rhs_f, rhs_b;

    always_comb begin
        maj   = x_major ? ax : ay;
        mnr   = x_major ? ay : ax;
        gap   = maj - mnr;
        lhs   = PW'(mag) * PW'(maj);
        rhs_f = PW'(mnr) * PW'(fwd_diag) + PW'(gap) * PW'(fwd_prim);
        rhs_b = PW'(mnr) * PW'(bwd_diag) + PW'(gap) * PW'(bwd_prim);
        keep  = (lhs >= rhs_f) && (lhs >= rhs_b);
    end
endmodule

// File: rtl/nms8_link.sv
module nms8_link
    import nms8_pkg::*;
(
    input  cls_t       centre,
    input  logic [7:0] nbr_strong,
    output logic       edge_bit
);
    always_comb begin
        unique case (centre)
            CLS_STRONG: edge_bit = 1'b1;
            CLS_WEAK:   edge_bit = |nbr_strong;
            default:    edge_bit = 1'b0;
        endcase
    end
endmodule

// File: rtl/edge_nms8.sv
module edge_nms8
    import nms8_pkg::*;
#(
    parameter int IMG_W = 16,
    parameter int IMG_H = 12,
    parameter int GW    = 11,
    parameter int MW    = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [MW-1:0] thr_hi,
    input  logic [MW-1:0] thr_lo,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic          in_sx,
    input  logic [GW-1:0] in_ax,
    input  logic          in_sy,
    input  logic [GW-1:0] in_ay,
    output logic          out_valid,
    output logic          out_edge
);
    localparam int NPIX = IMG_W * IMG_H;
    localparam int AW   = $clog2(NPIX);
    localparam int CW   = $clog2(IMG_W);
    localparam int RW   = $clog2(IMG_H);

    state_t        state_q, state_d;
    logic [AW-1:0] idx_q;
    logic [CW-1:0] col_q;
    logic [RW-1:0] row_q;
    logic [MW-1:0] hi_q, lo_q;
    logic          out_valid_q, out_edge_q;

    logic [MW-1:0] mag_mem  [NPIX];
    logic [GW-1:0] ax_mem   [NPIX];
    logic [GW-1:0] ay_mem   [NPIX];
    logic          sx_mem   [NPIX];
    logic          sy_mem   [NPIX];
    logic          xmaj_mem [NPIX];
    cls_t          cls_mem  [NPIX];

    logic accept, last, step;

    // ---------------- magnitude and sector at the input ----------------
    logic [MW-1:0] mag_in;
    logic          xmaj_in;

    nms8_mag #(.GW(GW), .MW(MW)) u_mag (
        .ax      (in_ax),
        .ay      (in_ay),
        .mag     (mag_in),
        .x_major (xmaj_in)
    );

    // R2: clamped sum never falls below either component
    p_mag_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (32'(mag_in) >= 32'(in_ax)) && (32'(mag_in) >= 32'(in_ay)));

    assign in_ready = (state_q == ST_LOAD);
    assign accept   = in_valid && in_ready;
    assign last     = (idx_q == AW'(NPIX - 1));
    assign step     = (state_q == ST_LOAD) ? accept : 1'b1;

    // R11: threshold order at the sampling cycle
    p_thr_order_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && last) |-> (thr_lo <= thr_hi));

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_LOAD;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOAD:     if (accept && last) state_d = ST_SUPPRESS;
            ST_SUPPRESS: if (last)           state_d = ST_LINK;
            ST_LINK:     if (last)           state_d = ST_LOAD;
            default:                         state_d = ST_LOAD;
        endcase
    end

    // R1: input stays closed through both walk phases
    p_closed_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && last) |=> !in_ready);

    // ---------------- raster position counters ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            col_q <= '0;
            row_q <= '0;
        end else if (step) begin
            if (last) begin
                idx_q <= '0;
                col_q <= '0;
                row_q <= '0;
            end else begin
                idx_q <= idx_q + 1'b1;
                if (col_q == CW'(IMG_W - 1)) begin
                    col_q <= '0;
                    row_q <= row_q + 1'b1;
                end else begin
                    col_q <= col_q + 1'b1;
                end
            end
        end
    end

    // R1: raster counters stay inside the frame
    p_raster_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(col_q) < IMG_W) && (int'(row_q) < IMG_H)
        && (int'(idx_q) == int'(row_q) * IMG_W + int'(col_q)));

    // R9: thresholds sampled at the last accepted pixel
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (accept && last) begin
            hi_q <= thr_hi;
            lo_q <= thr_lo;
        end
    end

    // R9: sampled thresholds hold while the frame is processed
    p_thr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_LOAD) && $past(state_q != ST_LOAD) |-> $stable(hi_q) && $stable(lo_q));

    // ---------------- frame storage ----------------
    always_ff @(posedge clk) begin
        if (accept) begin
            mag_mem[idx_q]  <= mag_in;
            ax_mem[idx_q]   <= in_ax;
            ay_mem[idx_q]   <= in_ay;
            sx_mem[idx_q]   <= in_sx;
            sy_mem[idx_q]   <= in_sy;
            xmaj_mem[idx_q] <= xmaj_in;
        end
    end

    function automatic logic [MW-1:0] mag_at(input int r, input int c);
        if (r < 0 || r >= IMG_H || c < 0 || c >= IMG_W) return '0;
        return mag_mem[AW'(r * IMG_W + c)];
    endfunction

    function automatic logic strong_at(input int r, input int c);
        if (r < 0 || r >= IMG_H || c < 0 || c >= IMG_W) return 1'b0;
        return cls_mem[AW'(r * IMG_W + c)] == CLS_STRONG;
    endfunction

    // ---------------- neighbour pick along the sector ----------------
    int            r_i, c_i, dx, dy;
    logic [MW-1:0] fp, fd, bp, bd;
    logic          keep;
    cls_t          cls_next;

    always_comb begin
        r_i = int'(row_q);
        c_i = int'(col_q);
        dx  = sx_mem[idx_q] ? -1 : 1;
        dy  = sy_mem[idx_q] ? -1 : 1;
        if (xmaj_mem[idx_q]) begin
            fp = mag_at(r_i,      c_i + dx);
            fd = mag_at(r_i + dy, c_i + dx);
            bp = mag_at(r_i,      c_i - dx);
            bd = mag_at(r_i - dy, c_i - dx);
        end else begin
            fp = mag_at(r_i + dy, c_i);
            fd = mag_at(r_i + dy, c_i + dx);
            bp = mag_at(r_i - dy, c_i);
            bd = mag_at(r_i - dy, c_i - dx);
        end
    end

    nms8_cmp #(.GW(GW), .MW(MW)) u_cmp (
        .mag      (mag_mem[idx_q]),
        .ax       (ax_mem[idx_q]),
        .ay       (ay_mem[idx_q]),
        .x_major  (xmaj_mem[idx_q]),
        .fwd_prim (fp),
        .fwd_diag (fd),
        .bwd_prim (bp),
        .bwd_diag (bd),
        .keep     (keep)
    );

    always_comb begin
        if (!keep)                        cls_next = CLS_NONE;
        else if (mag_mem[idx_q] >= hi_q)  cls_next = CLS_STRONG;
        else if (mag_mem[idx_q] >= lo_q)  cls_next = CLS_WEAK;
        else                              cls_next = CLS_NONE;
    end

    always_ff @(posedge clk) begin
        if (state_q == ST_SUPPRESS) cls_mem[idx_q] <= cls_next;
    end

    // R6: a strong grade is never given below the high threshold
    p_strong_above_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SUPPRESS && cls_next == CLS_STRONG) |-> (mag_mem[idx_q] >= hi_q));

    // R8: graded pixels never sit below the low threshold
    p_graded_above_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SUPPRESS && cls_next != CLS_NONE) |-> (mag_mem[idx_q] >= lo_q));

    // ---------------- 3x3 link window ----------------
    logic [7:0] nbr_strong;
    logic       edge_cur;

    always_comb begin
        nbr_strong = '0;
        for (int k = 0; k < 9; k++) begin
            if (k != 4) nbr_strong[(k < 4) ? k : k - 1] =
                strong_at(int'(row_q) + k / 3 - 1, int'(col_q) + k % 3 - 1);
        end
    end

    nms8_link u_link (
        .centre     (cls_mem[idx_q]),
        .nbr_strong (nbr_strong),
        .edge_bit   (edge_cur)
    );

    // ---------------- output process ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_q <= 1'b0;
            out_edge_q  <= 1'b0;
        end else begin
            out_valid_q <= (state_q == ST_LINK);
            out_edge_q  <= (state_q == ST_LINK) && edge_cur;
        end
    end

    assign out_valid = out_valid_q;
    assign out_edge  = out_edge_q;

    // R1: an edge bit is only ever raised with its valid
    p_edge_with_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_edge |-> out_valid);

    // R1: once input reopens, the output burst ends next cycle
    p_burst_end_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && in_ready) |=> !out_valid);
endmodule

// File: tb/edge_nms8_tb_top.sv
module edge_nms8_tb_top;
    localparam int IMG_W = 16;
    localparam int IMG_H = 12;
    localparam int GW    = 11;
    localparam int MW    = 11;
    localparam int NPIX  = IMG_W * IMG_H;
    localparam int MAXM  = (1 << MW) - 1;
    localparam int GMAX  = (1 << GW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [MW-1:0] thr_hi = '0, thr_lo = '0;
    logic          in_valid = 1'b0, in_sx = 1'b0, in_sy = 1'b0;
    logic [GW-1:0] in_ax = '0, in_ay = '0;
    logic          in_ready, out_valid, out_edge;

    edge_nms8 #(.IMG_W(IMG_W), .IMG_H(IMG_H), .GW(GW), .MW(MW)) dut_i (
        .clk(clk), .rst_n(rst_n), .thr_hi(thr_hi), .thr_lo(thr_lo),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_sx(in_sx), .in_ax(in_ax), .in_sy(in_sy), .in_ay(in_ay),
        .out_valid(out_valid), .out_edge(out_edge)
    );

    int n_chk = 0, n_fail = 0;
    int gsx[NPIX], gax[NPIX], gsy[NPIX], gay[NPIX];
    int emag[NPIX], ekeep[NPIX], ecls[NPIX], eedge[NPIX], got[NPIX], prev[NPIX];
    int frame_fail;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            frame_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int mg(input int r, input int c);
        if (r < 0 || r >= IMG_H || c < 0 || c >= IMG_W) return 0;
        return emag[r * IMG_W + c];
    endfunction

    function automatic int st(input int r, input int c);
        if (r < 0 || r >= IMG_H || c < 0 || c >= IMG_W) return 0;
        return (ecls[r * IMG_W + c] == 2) ? 1 : 0;
    endfunction

    function automatic bit side_ok(input int m, input int maj, input int mnr, input int p, input int d);
        return m * maj >= mnr * d + (maj - mnr) * p;
    endfunction

    task automatic model(input int hi, input int lo);
        for (int i = 0; i < NPIX; i++) begin
            emag[i] = gax[i] + gay[i];
            if (emag[i] > MAXM) emag[i] = MAXM;
        end
        for (int r = 0; r < IMG_H; r++)
            for (int c = 0; c < IMG_W; c++) begin
                int i, sdx, sdy, m;
                bit k;
                i   = r * IMG_W + c;
                m   = emag[i];
                sdx = gsx[i] ? -1 : 1;
                sdy = gsy[i] ? -1 : 1;
                if (gax[i] >= gay[i])
                    k = side_ok(m, gax[i], gay[i], mg(r, c + sdx), mg(r + sdy, c + sdx)) &&
                        side_ok(m, gax[i], gay[i], mg(r, c - sdx), mg(r - sdy, c - sdx));
                else
                    k = side_ok(m, gay[i], gax[i], mg(r + sdy, c), mg(r + sdy, c + sdx)) &&
                        side_ok(m, gay[i], gax[i], mg(r - sdy, c), mg(r - sdy, c - sdx));
                ekeep[i] = k;
                ecls[i]  = !k ? 0 : (m >= hi) ? 2 : (m >= lo) ? 1 : 0;
            end
        for (int r = 0; r < IMG_H; r++)
            for (int c = 0; c < IMG_W; c++) begin
                int i, any;
                i = r * IMG_W + c;
                any = 0;
                for (int dr = -1; dr <= 1; dr++)
                    for (int dc = -1; dc <= 1; dc++)
                        if (dr != 0 || dc != 0) any += st(r + dr, c + dc);
                eedge[i] = (ecls[i] == 2) || (ecls[i] == 1 && any > 0);
            end
    endtask

    task automatic fill_random(input int lo_v, input int hi_v);
        for (int i = 0; i < NPIX; i++) begin
            gsx[i] = int'($urandom_range(1, 0));
            gsy[i] = int'($urandom_range(1, 0));
            gax[i] = int'($urandom_range(hi_v, lo_v));
            gay[i] = int'($urandom_range(hi_v, lo_v));
        end
    endtask

    task automatic run_frame(input int hi, input int lo, input string tag, input bit busy_noise);
        int ocount, guard, early;
        thr_hi = MW'(hi);
        thr_lo = MW'(lo);
        frame_fail = 0;
        for (int i = 0; i < NPIX; i++) begin
            @(negedge clk);
            guard = 0;
            while (!in_ready && guard < 1000) begin @(negedge clk); guard++; end
            in_valid = 1'b1;
            in_sx = gsx[i][0]; in_sy = gsy[i][0];
            in_ax = GW'(gax[i]); in_ay = GW'(gay[i]);
        end
        ocount = 0; guard = 0; early = 0;
        while (ocount < NPIX && guard < 4 * NPIX + 20) begin
            @(negedge clk);
            guard++;
            if (busy_noise) begin
                in_valid = 1'b1;
                in_sx = 1'($urandom); in_sy = 1'($urandom);
                in_ax = GW'($urandom); in_ay = GW'($urandom);
                thr_lo = MW'($urandom_range(200, 0));
                thr_hi = MW'($urandom_range(400, 201));
            end else begin
                in_valid = 1'b0;
            end
            if (out_valid) begin
                got[ocount] = out_edge;
                if (in_ready && ocount != NPIX - 1) early++;
                if (!in_ready && ocount == NPIX - 1) early++;
                ocount++;
            end else if (in_ready) begin
                early++;
            end
            if (in_ready) in_valid = 1'b0;
        end
        in_valid = 1'b0;
        check(ocount == NPIX, "R1 output count", ocount, NPIX);
        check(early == 0, "R1 ready closed until last output", early, 0);
        @(negedge clk);
        check(out_valid == 1'b0, "R1 no extra output", out_valid, 0);
        model(hi, lo);
        for (int i = 0; i < NPIX; i++) begin
            int r, c;
            string t;
            r = i / IMG_W; c = i % IMG_W;
            if (r == 0 || c == 0 || r == IMG_H - 1 || c == IMG_W - 1) t = "R5 border pixel";
            else if (!ekeep[i])   t = "R4 suppressed pixel";
            else if (ecls[i] == 0) t = "R8 below low pixel";
            else if (ecls[i] == 2) t = "R6 strong pixel";
            else                   t = "R7 weak pixel";
            check(got[i] == eedge[i], $sformatf("%s (%0d,%0d) in %s", t, r, c, tag), got[i], eedge[i]);
        end
        check(frame_fail == 0, $sformatf("%s whole frame", tag), frame_fail, 0);
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1, "R1 reset ready", in_ready, 1);
        check(out_valid == 1'b0, "R1 reset valid", out_valid, 0);

        // random frames, mixed threshold settings
        fill_random(0, 300);
        run_frame(350, 120, "R4 random frame A", 1'b0);
        for (int i = 0; i < NPIX; i++) prev[i] = got[i];

        // R3: invert every sign, map must not change
        for (int i = 0; i < NPIX; i++) begin gsx[i] = 1 - gsx[i]; gsy[i] = 1 - gsy[i]; end
        run_frame(350, 120, "R3 mirrored frame", 1'b0);
        begin
            int diff = 0;
            for (int i = 0; i < NPIX; i++) if (got[i] != prev[i]) diff++;
            check(diff == 0, "R3 mirrored map equals original", diff, 0);
        end

        // R2: large gradients, saturation matters for thinning
        fill_random(1200, GMAX);
        run_frame(MAXM, 1500, "R2 saturation frame", 1'b0);

        // R11: equal thresholds
        fill_random(0, 400);
        run_frame(300, 300, "R11 equal thresholds", 1'b0);

        // R9 and R10: garbage and threshold changes while busy
        fill_random(0, 250);
        run_frame(260, 90, "R9 thresholds sampled", 1'b1);
        fill_random(0, 250);
        run_frame(240, 60, "R10 frame after busy stimulus", 1'b0);

        // zero low threshold, full range
        fill_random(0, 1000);
        run_frame(900, 0, "R8 zero low threshold", 1'b0);

        // sparse directed frame
        for (int i = 0; i < NPIX; i++) begin gsx[i] = 0; gsy[i] = 0; gax[i] = 0; gay[i] = 0; end
        gax[3 * IMG_W + 3] = 800;
        gay[4 * IMG_W + 4] = 200;
        gax[8 * IMG_W + 8] = 200;
        gax[0] = 700; gsx[0] = 1;
        run_frame(500, 100, "R7 sparse frame", 1'b0);
        check(got[3 * IMG_W + 3] == 1, "R6 lone strong pixel", got[3 * IMG_W + 3], 1);
        check(got[4 * IMG_W + 4] == 1, "R7 weak promoted by diagonal strong", got[4 * IMG_W + 4], 1);
        check(got[8 * IMG_W + 8] == 0, "R7 isolated weak cleared", got[8 * IMG_W + 8], 0);
        check(got[0] == 1, "R5 corner strong pixel", got[0], 1);
        check(got[5 * IMG_W + 10] == 0, "R8 zero pixel", got[5 * IMG_W + 10], 0);

        for (int f = 0; f < 3; f++) begin
            int h, l;
            fill_random(0, 120 + 200 * f);
            h = int'($urandom_range(300, 100));
            l = int'($urandom_range(h, 0));
            run_frame(h, l, "R4 random frame B", 1'b0);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule